// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches the write side of an asynchronous, byte-wide NOR-flash style bus and turns legal command sequences into single-cycle requests for a separate operation engine. It holds the bus address when the write strobe becomes active and the bus data when the strobe ends. A synchronizer carries the end of each write into the system clock domain. A small sequencer then walks the key-and-command handshakes for byte program, sector erase and block erase. It also recognises the one-write suspend and resume commands.

The engine reports two flags back: `eng_busy` while a program or erase runs, and `eng_suspended` while an erase is parked. These flags decide which writes count. The block remembers the region of the last erase it issued. It uses that region to refuse a program into a suspended area. A write-protect input shields one configurable 64 KiB block from erase.

Top module: `fcd_decoder`

## Requirements
- R1: The write address is the value on `addr` when the combined strobe (`ce_n` and `we_n` both low) becomes active, whichever pin falls last. The write data is the value on `data` when the strobe ends, whichever pin rises first. Changes on `addr` during the pulse and changes on `data` after the pulse are not taken.
- R2: A byte program is the four writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, then target address/data. It raises `req_valid` with `req_op`=0 and the fourth write's address and data. This happens in the third clock after the strobe of the fourth write ends.
- R3: An erase is six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the target address with 50h or 30h. Data 50h gives `req_op`=1 (4 KiB sector). Data 30h gives `req_op`=2 (64 KiB block).
- R4: A write that does not fit the expected next step returns the sequencer to idle without any request. That write does not itself start a new sequence. A correct sequence afterwards is decoded normally.
- R5: While `eng_busy` is high, a write with data B0h produces `req_op`=3 (suspend). Every other write is dropped and also cancels any partial sequence.
- R6: With `eng_busy` low and `eng_suspended` high, a single write of 30h at any address, starting from idle, produces `req_op`=4 (resume). The same write with `eng_suspended` low produces nothing.
- R7: While `wp_n` is low, a sector or block erase whose address lies in block PROT_BLOCK (address bits 20:16 equal 0 by default) is dropped. Erases elsewhere still go out.
- R8: While `eng_suspended` is high, two kinds of request are dropped. One is a program into the region of the last issued erase: the same 4 KiB sector after a sector erase, or the same 64 KiB block after a block erase. The other is any new erase. Programs outside that region are issued.
- R9: During reset `req_valid` is low.
- R10: `req_valid` is high for exactly one clock per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | 21 | Bus byte address |
| data | input | 8 | Bus write data |
| wp_n | input | 1 | Write protect, active low, held static |
| eng_busy | input | 1 | Engine is running a program or erase |
| eng_suspended | input | 1 | Engine holds a suspended erase |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 3 | 0 program, 1 sector erase, 2 block erase, 3 suspend, 4 resume |
| req_addr | output | 21 | Address of the final write of the sequence |
| req_data | output | 8 | Data of the final write of the sequence |

## Verification
Complete program and erase sequences are driven in two forms. In one, chip enable is the later falling pin and the earlier rising pin. In the other, write enable plays that role. The address is garbled inside the pulse and the data is garbled both inside the pulse and after it, which separates correct edge capture from sampling at the wrong moment. Sequences broken at the second, third and sixth step, and writes issued during busy and suspended phases, show that partial progress is thrown away. Erases and programs are aimed just inside and just outside the protected block and the suspended sector or block, which checks the region compare at its boundaries.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_SECT   = 3'd1,
        OP_BLOCK  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } fcd_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_ERA1,
        ST_ERA2,
        ST_ERA3
    } fcd_state_e;

    // Command byte table; the generate loop in fcd_cmd_match decodes it.
    localparam int unsigned NUM_CODES = 7;
    localparam int unsigned IX_KEY1   = 0;
    localparam int unsigned IX_KEY2   = 1;
    localparam int unsigned IX_PROG   = 2;
    localparam int unsigned IX_SETUP  = 3;
    localparam int unsigned IX_SECT   = 4;
    localparam int unsigned IX_BLKRES = 5;
    localparam int unsigned IX_SUSP   = 6;

    localparam logic [BYTE_W-1:0] CODE_TABLE [NUM_CODES] = '{
        8'hAA, 8'h55, 8'hA0, 8'h80, 8'h50, 8'h30, 8'hB0
    };

endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
    parameter int unsigned ADDR_W      = 21,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_lat,
    output logic [DATA_W-1:0] data_lat,
    output logic              wr_done
);

    logic strobe_act;
    assign strobe_act = ~ce_n & ~we_n;

    // Strobe turns on at the later falling pin: the address is held here.
    always_ff @(posedge strobe_act) begin
        addr_lat <= addr_in;
    end

    // Strobe turns off at the earlier rising pin: the data is held here.
    always_ff @(negedge strobe_act) begin
        data_lat <= data_in;
    end

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= strobe_act;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_act};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign wr_done = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/fcd_cmd_match.sv
module fcd_cmd_match
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned KEY_ADDR_A = 'h5555,
    parameter int unsigned KEY_ADDR_B = 'h2AAA
) (
    input  logic [ADDR_W-1:0]    addr_lat,
    input  logic [BYTE_W-1:0]    data_lat,
    output logic [NUM_CODES-1:0] code_hit,
    output logic                 at_key_a,
    output logic                 at_key_b
);

    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(KEY_ADDR_B);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CODES; gi++) begin : g_code
            assign code_hit[gi] = (data_lat == CODE_TABLE[gi]);
        end
    endgenerate

    assign at_key_a = (addr_lat == KEY_A);
    assign at_key_b = (addr_lat == KEY_B);

endmodule

// File: rtl/fcd_region_guard.sv
module fcd_region_guard #(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned SECTOR_AW  = 12,
    parameter int unsigned BLOCK_AW   = 16,
    parameter int unsigned PROT_BLOCK = 0
) (
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic              rec_block,
    output logic              in_prot_block,
    output logic              in_held_region
);

    localparam int unsigned BLK_IDX_W = ADDR_W - BLOCK_AW;
    localparam int unsigned SEC_IDX_W = ADDR_W - SECTOR_AW;

    logic [BLK_IDX_W-1:0] tgt_blk;
    logic [SEC_IDX_W-1:0] tgt_sec;
    logic                 same_blk;
    logic                 same_sec;

    assign tgt_blk  = tgt_addr[ADDR_W-1:BLOCK_AW];
    assign tgt_sec  = tgt_addr[ADDR_W-1:SECTOR_AW];
    assign same_blk = (tgt_blk == rec_addr[ADDR_W-1:BLOCK_AW]);
    assign same_sec = (tgt_sec == rec_addr[ADDR_W-1:SECTOR_AW]);

    assign in_prot_block  = (tgt_blk == BLK_IDX_W'(PROT_BLOCK));
    assign in_held_region = rec_block ? same_blk : same_sec;

endmodule

// File: rtl/fcd_decoder.sv
module fcd_decoder
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 21,
    parameter int unsigned SECTOR_AW   = 12,
    parameter int unsigned BLOCK_AW    = 16,
    parameter int unsigned PROT_BLOCK  = 0,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned KEY_ADDR_A  = 'h5555,
    parameter int unsigned KEY_ADDR_B  = 'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    input  logic              wp_n,
    input  logic              eng_busy,
    input  logic              eng_suspended,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data
);

    typedef struct packed {
        fcd_state_e        state;
        logic              req_valid;
        fcd_op_e           req_op;
        logic [ADDR_W-1:0] req_addr;
        logic [BYTE_W-1:0] req_data;
        logic [ADDR_W-1:0] rec_addr;
        logic              rec_block;
    } dec_regs_t;

    logic [ADDR_W-1:0]    addr_lat;
    logic [BYTE_W-1:0]    data_lat;
    logic                 wr_done;
    logic [NUM_CODES-1:0] code_hit;
    logic                 at_key_a;
    logic                 at_key_b;
    logic                 in_prot_block;
    logic                 in_held_region;

    fcd_bus_capture #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (BYTE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr_in  (addr),
        .data_in  (data),
        .addr_lat (addr_lat),
        .data_lat (data_lat),
        .wr_done  (wr_done)
    );

    fcd_cmd_match #(
        .ADDR_W     (ADDR_W),
        .KEY_ADDR_A (KEY_ADDR_A),
        .KEY_ADDR_B (KEY_ADDR_B)
    ) u_match (
        .addr_lat (addr_lat),
        .data_lat (data_lat),
        .code_hit (code_hit),
        .at_key_a (at_key_a),
        .at_key_b (at_key_b)
    );

    dec_regs_t d;
    dec_regs_t q;

    fcd_region_guard #(
        .ADDR_W     (ADDR_W),
        .SECTOR_AW  (SECTOR_AW),
        .BLOCK_AW   (BLOCK_AW),
        .PROT_BLOCK (PROT_BLOCK)
    ) u_guard (
        .tgt_addr       (addr_lat),
        .rec_addr       (q.rec_addr),
        .rec_block      (q.rec_block),
        .in_prot_block  (in_prot_block),
        .in_held_region (in_held_region)
    );

    logic key1_d;
    logic key2_d;
    logic erase_code_d;
    logic erase_blocked_d;
    logic prog_blocked_d;

    assign key1_d          = at_key_a & code_hit[IX_KEY1];
    assign key2_d          = at_key_b & code_hit[IX_KEY2];
    assign erase_code_d    = code_hit[IX_SECT] | code_hit[IX_BLKRES];
    assign erase_blocked_d = eng_suspended | (~wp_n & in_prot_block);
    assign prog_blocked_d  = eng_suspended & in_held_region;

    always_comb begin
        d           = q;
        d.req_valid = 1'b0;
        if (wr_done) begin
            d.state = ST_IDLE;
            if (eng_busy) begin
                if (code_hit[IX_SUSP]) begin
                    d.req_valid = 1'b1;
                    d.req_op    = OP_SUSP;
                    d.req_addr  = addr_lat;
                    d.req_data  = data_lat;
                end
            end else begin
                unique case (q.state)
                    ST_IDLE: begin
                        if (key1_d) begin
                            d.state = ST_KEY1;
                        end else if (code_hit[IX_BLKRES] && eng_suspended) begin
                            d.req_valid = 1'b1;
                            d.req_op    = OP_RESUME;
                            d.req_addr  = addr_lat;
                            d.req_data  = data_lat;
                        end
                    end
                    ST_KEY1: begin
                        if (key2_d) d.state = ST_KEY2;
                    end
                    ST_KEY2: begin
                        if (at_key_a && code_hit[IX_PROG]) begin
                            d.state = ST_PROG;
                        end else if (at_key_a && code_hit[IX_SETUP]) begin
                            d.state = ST_ERA1;
                        end
                    end
                    ST_PROG: begin
                        if (!prog_blocked_d) begin
                            d.req_valid = 1'b1;
                            d.req_op    = OP_PROG;
                            d.req_addr  = addr_lat;
                            d.req_data  = data_lat;
                        end
                    end
                    ST_ERA1: begin
                        if (key1_d) d.state = ST_ERA2;
                    end
                    ST_ERA2: begin
                        if (key2_d) d.state = ST_ERA3;
                    end
                    ST_ERA3: begin
                        if (erase_code_d && !erase_blocked_d) begin
                            d.req_valid = 1'b1;
                            d.req_op    = code_hit[IX_SECT] ? OP_SECT : OP_BLOCK;
                            d.req_addr  = addr_lat;
                            d.req_data  = data_lat;
                            d.rec_addr  = addr_lat;
                            d.rec_block = code_hit[IX_BLKRES];
                        end
                    end
                    default: d.state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.req_valid <= 1'b0;
            q.req_op    <= OP_PROG;
            q.req_addr  <= '0;
            q.req_data  <= '0;
            q.rec_addr  <= '0;
            q.rec_block <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_valid = q.req_valid;
    assign req_op    = q.req_op;
    assign req_addr  = q.req_addr;
    assign req_data  = q.req_data;

endmodule

// File: rtl/fcd_decoder_chk.sv
module fcd_decoder_chk
    import fcd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 21,
    parameter int unsigned BLOCK_AW   = 16,
    parameter int unsigned PROT_BLOCK = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              eng_busy,
    input logic              eng_suspended,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr
);

    localparam int unsigned BLK_IDX_W = ADDR_W - BLOCK_AW;

    logic is_erase;
    assign is_erase = (req_op == OP_SECT) || (req_op == OP_BLOCK);

    // R10: each request lasts one clock
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R5: while the engine runs only suspend leaves the block
    assert_busy_only_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(eng_busy)) |-> (req_op == OP_SUSP));

    // R6: resume only from a parked, idle engine
    assert_resume_needs_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RESUME) |-> ($past(eng_suspended) && !$past(eng_busy)));

    // R7: no erase into the shielded block while protection is on
    assert_protected_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_erase && !$past(wp_n))
            |-> (req_addr[ADDR_W-1:BLOCK_AW] != BLK_IDX_W'(PROT_BLOCK)));

    // R8: no new erase while one is parked
    assert_no_erase_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_erase) |-> !$past(eng_suspended));

endmodule

bind fcd_decoder fcd_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .BLOCK_AW   (BLOCK_AW),
    .PROT_BLOCK (PROT_BLOCK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp_n          (wp_n),
    .eng_busy      (eng_busy),
    .eng_suspended (eng_suspended),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_addr      (req_addr)
);

// File: tb/fcd_decoder_tb.sv
module fcd_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [20:0] addr = '0;
    logic [7:0]  data = '0;
    logic        wp_n = 1'b1;
    logic        eng_busy = 1'b0;
    logic        eng_suspended = 1'b0;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [20:0] req_addr;
    logic [7:0]  req_data;

    fcd_decoder u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .we_n          (we_n),
        .addr          (addr),
        .data          (data),
        .wp_n          (wp_n),
        .eng_busy      (eng_busy),
        .eng_suspended (eng_suspended),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_data      (req_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        int    op;
        int    a;
        int    d;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    hist_a[$];
    int    hist_d[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    int    rec_a = 0;
    bit    rec_blk = 1'b0;
    bit    finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit step_ok(int idx, int a, int d, bit erase);
        case (idx)
            0: return a == 'h5555 && d == 'hAA;
            1: return a == 'h2AAA && d == 'h55;
            2: return a == 'h5555 && d == (erase ? 'h80 : 'hA0);
            3: return erase ? (a == 'h5555 && d == 'hAA) : 1'b1;
            4: return erase && a == 'h2AAA && d == 'h55;
            5: return erase && (d == 'h50 || d == 'h30);
            default: return 1'b0;
        endcase
    endfunction

    function automatic void expect_req(int op, int a, int d);
        exp_t e;
        e.due = cyc + 3;
        e.op  = op;
        e.a   = a;
        e.d   = d;
        e.tag = cur_req;
        exp_q.push_back(e);
    endfunction

    function automatic void model_write(int a, int d);
        bit pm;
        bit em;
        int n;
        hist_a.push_back(a);
        hist_d.push_back(d);
        n = hist_a.size();
        if (eng_busy) begin
            hist_a.delete();
            hist_d.delete();
            if (d == 'hB0) expect_req(3, a, d);
            return;
        end
        pm = (n <= 4);
        em = (n <= 6);
        for (int i = 0; i < n; i++) begin
            if (!step_ok(i, hist_a[i], hist_d[i], 1'b0)) pm = 1'b0;
            if (!step_ok(i, hist_a[i], hist_d[i], 1'b1)) em = 1'b0;
        end
        if (pm && n == 4) begin
            bit held;
            held = rec_blk ? ((a >> 16) == (rec_a >> 16)) : ((a >> 12) == (rec_a >> 12));
            hist_a.delete();
            hist_d.delete();
            if (!(eng_suspended && held)) expect_req(0, a, d);
            return;
        end
        if (em && n == 6) begin
            hist_a.delete();
            hist_d.delete();
            if (!eng_suspended && !(!wp_n && (a >> 16) == 0)) begin
                expect_req(d == 'h50 ? 1 : 2, a, d);
                rec_a   = a;
                rec_blk = (d == 'h30);
            end
            return;
        end
        if (pm || em) return;
        if (n == 1 && d == 'h30 && eng_suspended) expect_req(4, a, d);
        hist_a.delete();
        hist_d.delete();
    endfunction

    // One bus write; ce_ctrl picks which pin falls last and rises first.
    task automatic bus_write(input int a, input int d, input bit ce_ctrl);
        @(negedge clk);
        addr = 21'(a);
        data = ~8'(d);
        if (ce_ctrl) begin
            we_n = 1'b0;
            #1 ce_n = 1'b0;
        end else begin
            ce_n = 1'b0;
            #1 we_n = 1'b0;
        end
        #1 addr = ~21'(a);
        @(negedge clk);
        data = 8'(d);
        @(negedge clk);
        if (ce_ctrl) ce_n = 1'b1;
        else         we_n = 1'b1;
        model_write(a, d);
        #1 data = ~8'(d);
        #1;
        if (ce_ctrl) we_n = 1'b1;
        else         ce_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_prog(input int a, input int d, input bit ce_ctrl);
        bus_write('h5555, 'hAA, ce_ctrl);
        bus_write('h2AAA, 'h55, ce_ctrl);
        bus_write('h5555, 'hA0, ce_ctrl);
        bus_write(a, d, ce_ctrl);
    endtask

    task automatic do_erase(input int a, input int cmd);
        bus_write('h5555, 'hAA, 1'b0);
        bus_write('h2AAA, 'h55, 1'b1);
        bus_write('h5555, 'h80, 1'b0);
        bus_write('h5555, 'hAA, 1'b1);
        bus_write('h2AAA, 'h55, 1'b0);
        bus_write(a, cmd, 1'b1);
    endtask

    // Per-clock comparison against the reference queue.
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                n_cmp++;
                if (req_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R9 req_valid in reset: actual %b expected 0", req_valid);
                end
            end else if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (req_valid !== 1'b1 || int'(req_op) != e.op ||
                    int'(req_addr) != e.a || int'(req_data) != e.d) begin
                    n_bad++;
                    $display("FAIL %s request: actual v=%b op=%0d a=%h d=%h expected v=1 op=%0d a=%h d=%h",
                             e.tag, req_valid, req_op, req_addr, req_data, e.op, e.a, e.d);
                end
            end else begin
                n_cmp++;
                if (req_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL %s unexpected request: actual v=%b op=%0d a=%h expected v=0",
                             cur_req, req_valid, req_op, req_addr);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R9";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 and R1: write-enable-controlled, then chip-enable-controlled
        cur_req = "R2";
        do_prog('h01234, 'h5A, 1'b0);
        cur_req = "R1";
        do_prog('h1ABCD, 'hC3, 1'b1);

        // R3: sector and block erase
        cur_req = "R3";
        do_erase('h13000, 'h50);
        do_erase('h20000, 'h30);

        // R4: broken at step two, three and six, then a clean program
        cur_req = "R4";
        bus_write('h5555, 'hAA, 1'b0);
        bus_write('h1234, 'h55, 1'b0);
        bus_write('h5555, 'hAA, 1'b0);
        bus_write('h2AAA, 'h55, 1'b0);
        bus_write('h5555, 'h77, 1'b0);
        bus_write('h5555, 'hAA, 1'b0);
        bus_write('h2AAA, 'h55, 1'b0);
        bus_write('h5555, 'h80, 1'b0);
        bus_write('h5555, 'hAA, 1'b0);
        bus_write('h2AAA, 'h55, 1'b0);
        bus_write('h30000, 'h10, 1'b0);
        do_prog('h00FFF, 'h01, 1'b0);

        // R6: resume with nothing parked is dropped
        cur_req = "R6";
        bus_write('h00777, 'h30, 1'b0);

        // R5: busy engine drops everything but suspend
        cur_req = "R5";
        eng_busy = 1'b1;
        do_prog('h04000, 'h11, 1'b0);
        bus_write('h00042, 'h30, 1'b0);
        bus_write('h00099, 'hB0, 1'b1);
        eng_busy = 1'b0;

        // R8: sector record is 20000 block now; first set a sector record
        cur_req = "R8";
        do_erase('h13000, 'h50);
        eng_suspended = 1'b1;
        do_prog('h13FFF, 'h22, 1'b0);
        do_prog('h14000, 'h23, 1'b1);
        do_prog('h12FFF, 'h24, 1'b0);
        do_erase('h30000, 'h30);
        cur_req = "R6";
        bus_write('h1F00F, 'h30, 1'b0);
        eng_suspended = 1'b0;
        cur_req = "R8";
        do_erase('h20000, 'h30);
        eng_suspended = 1'b1;
        do_prog('h2F000, 'h31, 1'b0);
        do_prog('h30000, 'h32, 1'b0);
        do_prog('h1FFFF, 'h33, 1'b1);
        eng_suspended = 1'b0;

        // R7: protected block 0 shielded only while wp_n is low
        cur_req = "R7";
        wp_n = 1'b0;
        do_erase('h0F000, 'h50);
        do_erase('h00000, 'h30);
        do_erase('h10000, 'h30);
        wp_n = 1'b1;
        do_erase('h00000, 'h30);

        // R10: pulse width covered by the per-clock compare throughout
        cur_req = "R10";
        repeat (10) @(negedge clk);

        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 pending requests: actual %0d expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule